// File: doc/BRIEF.md
# Strap-Addressed I2C Register Bank

This block is a fast-mode I2C target that gives a host processor access to a small file of configuration and status registers. The bus lines are first synchronised to the system clock. They then pass through a majority filter, so short spikes never reach the protocol engine. One bit of the 7-bit target address comes from a strap pin, which lets two copies share a bus. The engine keeps a register pointer. The first byte of a write sets it. Every data byte, read or written, advances it by one. A read that is not preceded by a pointer write resumes wherever the pointer stands.

The register file holds a fixed identification byte, a port-role register, a control register and an event mask. Status and type bytes come from outside and are read back live. Four interrupt flags are set by outside pulses and cleared when the host reads them. A command register turns host writes into one-cycle pulses, except for its disable bit, which holds. A soft-reset register returns every register to its reset value. The register contents are presented as parallel outputs for the rest of the port logic.

Top module: `i2c_strap_regbank`

## Requirements
- R1: The target acknowledges only the address byte whose bits 7 down to 1 are 0,1,0,0,S,0,1, where S is `addr_strap_i`. Bit 0 selects read when 1. Any other address is not acknowledged and changes no register.
- R2: After reset the ID register at 0x01 reads 0x12, 0x02 reads 0x04 and 0x03 reads 0x03. The registers at 0x10 and 0x13 read 0x00, and `sda_oe_o` is low.
- R3: In a write transfer the first data byte loads the pointer. Each following byte is written to the pointed register, and the pointer then increments by one. Each of these bytes is acknowledged.
- R4: A read transfer returns the register at the current pointer and increments the pointer after each byte. This holds whether or not a pointer write came first. Bytes keep coming until the host answers one with NACK.
- R5: Addresses 0x00, 0x06 to 0x0F and 0x14 upward read 0x00, and writes to them are dropped. Only these bits are writable: bits 5:0 at 0x02, bits 5:4 and 2:0 at 0x03, and bits 3:0 at 0x10. Every other bit reads 0.
- R6: The ID register is read-only: a write to 0x01 leaves it at 0x12.
- R7: 0x11 reads `status_i` with bits 7:6 forced to 0. 0x12 reads `type_i` with bits 7:5 and 2 forced to 0.
- R8: A pulse on `irq_set_i[k]` sets interrupt flag k. A read of 0x13 returns the flags in bits 3:0 and clears them. A flag never rises without a set pulse.
- R9: A write to 0x04 selects one command by priority: disable (bit 1), then error recovery (bit 0), then source (bit 2), then sink (bit 3). A selected bit 0, 2 or 3 appears on `man_cmd_o` for exactly one cycle. Disable stays set on `man_cmd_o[1]` and reads back as 0x02 until a write to 0x04 with bit 1 at 0.
- R10: Writing 1 to bit 0 of 0x05 gives a one-cycle `soft_rst_o` pulse. In the next cycle every register returns to its R2 value, with the flags and the disable bit cleared. 0x05 reads 0x00.
- R11: Pulses on SCL or SDA shorter than half of `FILT_TAPS` clock cycles are ignored. With the default of 13 taps this covers 6 cycles (48 ns).
- R12: `sda_oe_o` changes only while the filtered SCL is low. It is asserted for the acknowledge bit of every accepted byte, and carries read data most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap_i | input | 1 | Strap for address bit 3 of the address byte |
| status_i | input | 8 | Live status byte read at 0x11 |
| type_i | input | 8 | Live partner-type byte read at 0x12 |
| irq_set_i | input | 4 | Set pulses for the four interrupt flags |
| mode_o | output | 8 | Port-role register 0x02 |
| ctrl_o | output | 8 | Control register 0x03 |
| mask_o | output | 8 | Event mask register 0x10 |
| irq_flags_o | output | 4 | Pending interrupt flags (register 0x13) |
| man_cmd_o | output | 4 | Command register 0x04: pulses plus held disable |
| soft_rst_o | output | 1 | One-cycle pulse on a soft-reset write |

## Verification
The protocol engine is visible at the pins only through `sda_oe_o`. A wrong pointer or bit counter therefore shows up as a wrong data byte or a missing acknowledge within the same byte period, roughly nine SCL periods. A wrong register write shows on `mode_o`, `ctrl_o`, `mask_o` or `man_cmd_o` as soon as the bus goes idle, and the bench compares these against its model on every clock. A flag cleared or set at the wrong moment appears on `irq_flags_o` within one cycle. It also appears in the byte the next read of 0x13 returns.

// File: rtl/i2c_rb_pkg.sv
// Package: register offsets, reset values, writable-bit masks and the
// bus-engine state type shared by the register bank modules.
package i2c_rb_pkg;

    localparam logic [7:0] ADR_ID     = 8'h01;
    localparam logic [7:0] ADR_ROLE   = 8'h02;
    localparam logic [7:0] ADR_CTRL   = 8'h03;
    localparam logic [7:0] ADR_CMD    = 8'h04;
    localparam logic [7:0] ADR_SRST   = 8'h05;
    localparam logic [7:0] ADR_MASK   = 8'h10;
    localparam logic [7:0] ADR_STAT   = 8'h11;
    localparam logic [7:0] ADR_TYPE   = 8'h12;
    localparam logic [7:0] ADR_FLAGS  = 8'h13;

    localparam logic [7:0] RST_ROLE   = 8'h04;
    localparam logic [7:0] RST_CTRL   = 8'h03;

    localparam logic [7:0] WM_ROLE    = 8'h3F;
    localparam logic [7:0] WM_CTRL    = 8'h37;
    localparam logic [7:0] WM_MASK    = 8'h0F;
    localparam logic [7:0] RM_STAT    = 8'h3F;
    localparam logic [7:0] RM_TYPE    = 8'h1B;

    localparam int NFLAG = 4;
    localparam int NCMD  = 4;
    localparam int CMD_ERR  = 0;
    localparam int CMD_DIS  = 1;
    localparam int CMD_SRC  = 2;
    localparam int CMD_SNK  = 3;

    localparam logic [3:0] DEV_HI = 4'b0100;
    localparam logic [1:0] DEV_LO = 2'b01;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_RX,
        BS_RX_ACK,
        BS_TX,
        BS_TX_ACK
    } bus_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
// Line filter: two-flop synchroniser followed by a TAPS-wide majority
// window. Assumes TAPS is odd and at least 3; the idle (reset) level is 1.
module i2c_line_filter #(
    parameter int TAPS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = TAPS / 2;
    localparam int CW   = $clog2(TAPS + 1);

    logic [1:0]      sync_q;
    logic [TAPS-1:0] win_q;
    logic [CW-1:0]   ones;

    // Count the high samples held in the window.
    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + CW'(win_q[i]);
        end
    end

    // Synchronise, shift the window and register the majority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            win_q  <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            win_q  <= {win_q[TAPS-2:0], sync_q[1]};
            line_o <= (ones > CW'(HALF));
        end
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
// Bus engine: detects START/STOP and SCL edges on filtered lines, matches
// the strap-dependent address, keeps the auto-incrementing pointer and
// drives SDA low for acknowledges and read data. Assumes filtered inputs
// and no clock stretching.
module i2c_slave_fsm
    import i2c_rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       strap_i,
    input  logic [7:0] rd_data_i,
    output logic       wr_en_o,
    output logic [7:0] wr_data_o,
    output logic       rd_en_o,
    output logic [7:0] ptr_o,
    output logic       sda_oe_o
);
    bus_state_t state_q;
    logic       scl_d, sda_d;
    logic [2:0] bit_cnt;
    logic [7:0] shreg, txreg, ptr_q;
    logic       byte_done, first_wr, rw_q, master_ack, sda_oe_q;
    logic       scl_rise, scl_fall, start_c, stop_c, addr_hit;
    logic [6:0] own_addr;

    // Delay the filtered lines by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Bus events and address comparison.
    always_comb begin
        scl_rise = scl_f & ~scl_d;
        scl_fall = ~scl_f & scl_d;
        start_c  = scl_f & scl_d & sda_d & ~sda_f;
        stop_c   = scl_f & scl_d & ~sda_d & sda_f;
        own_addr = {DEV_HI, strap_i, DEV_LO};
        addr_hit = (shreg[7:1] == own_addr);
    end

    // Register-file strobes, issued in the cycle that owns the pointer value.
    always_comb begin
        rd_en_o = ((state_q == BS_ADDR) && scl_fall && byte_done && addr_hit && shreg[0])
               || ((state_q == BS_TX_ACK) && scl_fall && master_ack);
        wr_en_o = (state_q == BS_RX) && scl_fall && byte_done && !first_wr;
        wr_data_o = shreg;
        ptr_o     = ptr_q;
        sda_oe_o  = sda_oe_q;
    end

    // Transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= BS_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            ptr_q      <= '0;
            byte_done  <= 1'b0;
            first_wr   <= 1'b0;
            rw_q       <= 1'b0;
            master_ack <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else if (start_c) begin
            state_q   <= BS_ADDR;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else if (stop_c) begin
            state_q   <= BS_IDLE;
            byte_done <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else begin
            case (state_q)
                BS_ADDR, BS_RX: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_f};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) byte_done <= 1'b1;
                    end else if (scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        if (state_q == BS_ADDR) begin
                            if (addr_hit) begin
                                sda_oe_q <= 1'b1;
                                state_q  <= BS_ADDR_ACK;
                                first_wr <= 1'b1;
                                rw_q     <= shreg[0];
                                if (shreg[0]) begin
                                    txreg <= rd_data_i;
                                    ptr_q <= ptr_q + 8'd1;
                                end
                            end else begin
                                state_q <= BS_IDLE;
                            end
                        end else begin
                            sda_oe_q <= 1'b1;
                            state_q  <= BS_RX_ACK;
                            if (first_wr) begin
                                ptr_q    <= shreg;
                                first_wr <= 1'b0;
                            end else begin
                                ptr_q <= ptr_q + 8'd1;
                            end
                        end
                    end
                end
                BS_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            state_q  <= BS_TX;
                            sda_oe_q <= ~txreg[7];
                        end else begin
                            state_q  <= BS_RX;
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                BS_RX_ACK: begin
                    if (scl_fall) begin
                        sda_oe_q <= 1'b0;
                        bit_cnt  <= '0;
                        state_q  <= BS_RX;
                    end
                end
                BS_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) byte_done <= 1'b1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            byte_done <= 1'b0;
                            sda_oe_q  <= 1'b0;
                            state_q   <= BS_TX_ACK;
                        end else begin
                            txreg    <= {txreg[6:0], 1'b0};
                            sda_oe_q <= ~txreg[6];
                        end
                    end
                end
                BS_TX_ACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_f;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            txreg    <= rd_data_i;
                            sda_oe_q <= ~rd_data_i[7];
                            ptr_q    <= ptr_q + 8'd1;
                            bit_cnt  <= '0;
                            state_q  <= BS_TX;
                        end else begin
                            state_q <= BS_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_reg_file.sv
// Register file: stored role/control/mask/command registers, live status
// and type inputs, read-clear interrupt flags and the soft-reset sequencer.
// Assumes a write and a read strobe never fall in consecutive cycles.
module i2c_reg_file
    import i2c_rb_pkg::*;
#(
    parameter logic [7:0] ID_VALUE = 8'h12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_en_i,
    input  logic [7:0]       addr_i,
    output logic [7:0]       rd_data_o,
    input  logic [7:0]       status_i,
    input  logic [7:0]       type_i,
    input  logic [NFLAG-1:0] irq_set_i,
    output logic [7:0]       mode_o,
    output logic [7:0]       ctrl_o,
    output logic [7:0]       mask_o,
    output logic [NFLAG-1:0] irq_flags_o,
    output logic [NCMD-1:0]  man_cmd_o,
    output logic             soft_rst_o
);
    logic [7:0]       role_q, ctrl_q, mask_q;
    logic [NFLAG-1:0] flags_q, flag_clr;
    logic [NCMD-1:0]  cmd_q, cmd_pick;
    logic             srst_q;

    // Resolve a command write to one selected bit by priority.
    always_comb begin
        cmd_pick = '0;
        if (wr_data_i[CMD_DIS])      cmd_pick[CMD_DIS] = 1'b1;
        else if (wr_data_i[CMD_ERR]) cmd_pick[CMD_ERR] = 1'b1;
        else if (wr_data_i[CMD_SRC]) cmd_pick[CMD_SRC] = 1'b1;
        else if (wr_data_i[CMD_SNK]) cmd_pick[CMD_SNK] = 1'b1;
    end

    // Clear all flags when the flag register is fetched for the bus.
    always_comb begin
        flag_clr = (rd_en_i && addr_i == ADR_FLAGS) ? '1 : '0;
    end

    // Register updates; a soft reset behaves like the hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            role_q  <= RST_ROLE;
            ctrl_q  <= RST_CTRL;
            mask_q  <= '0;
            flags_q <= '0;
            cmd_q   <= '0;
            srst_q  <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | irq_set_i;
            cmd_q   <= cmd_q & NCMD'(1 << CMD_DIS);
            if (wr_en_i) begin
                case (addr_i)
                    ADR_ROLE: role_q <= wr_data_i & WM_ROLE;
                    ADR_CTRL: ctrl_q <= wr_data_i & WM_CTRL;
                    ADR_MASK: mask_q <= wr_data_i & WM_MASK;
                    ADR_CMD:  cmd_q  <= cmd_pick;
                    ADR_SRST: srst_q <= wr_data_i[0];
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; unlisted addresses return zero.
    always_comb begin
        case (addr_i)
            ADR_ID:    rd_data_o = ID_VALUE;
            ADR_ROLE:  rd_data_o = role_q;
            ADR_CTRL:  rd_data_o = ctrl_q;
            ADR_CMD:   rd_data_o = {{(8-NCMD){1'b0}}, cmd_q};
            ADR_MASK:  rd_data_o = mask_q;
            ADR_STAT:  rd_data_o = status_i & RM_STAT;
            ADR_TYPE:  rd_data_o = type_i & RM_TYPE;
            ADR_FLAGS: rd_data_o = {{(8-NFLAG){1'b0}}, flags_q};
            default:   rd_data_o = 8'h00;
        endcase
    end

    // Drive the parallel register outputs.
    always_comb begin
        mode_o      = role_q;
        ctrl_o      = ctrl_q;
        mask_o      = mask_q;
        irq_flags_o = flags_q;
        man_cmd_o   = cmd_q;
        soft_rst_o  = srst_q;
    end
endmodule

// File: rtl/i2c_strap_regbank.sv
// Top: filters both bus lines, runs the bus engine and the register file.
// Assumes SCL low and high phases each last well over FILT_TAPS cycles.
module i2c_strap_regbank
    import i2c_rb_pkg::*;
#(
    parameter int         FILT_TAPS = 13,
    parameter logic [7:0] ID_VALUE  = 8'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       addr_strap_i,
    input  logic [7:0] status_i,
    input  logic [7:0] type_i,
    input  logic [3:0] irq_set_i,
    output logic [7:0] mode_o,
    output logic [7:0] ctrl_o,
    output logic [7:0] mask_o,
    output logic [3:0] irq_flags_o,
    output logic [3:0] man_cmd_o,
    output logic       soft_rst_o
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines, flt_lines;
    logic             scl_flt, sda_flt;
    logic             wr_en, rd_en;
    logic [7:0]       wr_data, rd_data, ptr;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        i2c_line_filter #(.TAPS(FILT_TAPS)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[0];
    assign sda_flt = flt_lines[1];

    i2c_slave_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_flt),
        .sda_f     (sda_flt),
        .strap_i   (addr_strap_i),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .rd_en_o   (rd_en),
        .ptr_o     (ptr),
        .sda_oe_o  (sda_oe_o)
    );

    i2c_reg_file #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_en_i     (rd_en),
        .addr_i      (ptr),
        .rd_data_o   (rd_data),
        .status_i    (status_i),
        .type_i      (type_i),
        .irq_set_i   (irq_set_i),
        .mode_o      (mode_o),
        .ctrl_o      (ctrl_o),
        .mask_o      (mask_o),
        .irq_flags_o (irq_flags_o),
        .man_cmd_o   (man_cmd_o),
        .soft_rst_o  (soft_rst_o)
    );
endmodule

// File: rtl/i2c_strap_regbank_chk.sv
// Checker bound to the top: bus-line discipline, command pulses, flag
// origin and the reset paths.
module i2c_strap_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic [7:0] mode,
    input logic [7:0] ctrl,
    input logic [7:0] mask,
    input logic [3:0] irq_flags,
    input logic [3:0] irq_set,
    input logic [3:0] man_cmd,
    input logic       soft_rst
);
    assert_reset_values_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode == 8'h04 && ctrl == 8'h03 && mask == 8'h00 && irq_flags == 4'h0));

    assert_flag_needs_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flags & ~$past(irq_flags) & ~$past(irq_set)) == 4'h0));

    assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(man_cmd));

    assert_cmd_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((man_cmd & 4'b1101) != 4'h0) |=> ((man_cmd & 4'b1101) == 4'h0));

    assert_soft_reset_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode == 8'h04 && ctrl == 8'h03 && mask == 8'h00
                      && irq_flags == 4'h0 && man_cmd == 4'h0 && !soft_rst));

    assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
endmodule

bind i2c_strap_regbank i2c_strap_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_flt),
    .sda_oe    (sda_oe_o),
    .mode      (mode_o),
    .ctrl      (ctrl_o),
    .mask      (mask_o),
    .irq_flags (irq_flags_o),
    .irq_set   (irq_set_i),
    .man_cmd   (man_cmd_o),
    .soft_rst  (soft_rst_o)
);

// File: tb/sim_i2c_strap_regbank.sv
module sim_i2c_strap_regbank;
    localparam int Q = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, gl_scl = 1'b0, gl_sda = 1'b0;
    logic strap = 1'b0;
    logic [7:0] status_v = 8'h00, type_v = 8'h00;
    logic [3:0] irq_set = 4'h0;
    logic sda_oe, soft_rst;
    logic [7:0] mode_o, ctrl_o, mask_o;
    logic [3:0] irq_flags, man_cmd;
    wire  sda_line = sda_m & ~sda_oe;
    wire  scl_in = scl_m | gl_scl;
    wire  sda_in = sda_line & ~gl_sda;

    int checks = 0, fails = 0, cycles = 0;
    bit cmp_en = 1'b0;
    logic [7:0] e_mode = 8'h04, e_ctrl = 8'h03, e_mask = 8'h00, e_ptr = 8'h00;
    logic [3:0] e_flags = 4'h0, e_pulse = 4'h0, seen_pulse = 4'h0;
    logic e_dis = 1'b0;
    int e_pulse_n = 0, pulse_n = 0, srst_n = 0, e_srst_n = 0;
    logic [7:0] wq[$];

    always #4 clk = ~clk;

    i2c_strap_regbank u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in), .sda_oe_o(sda_oe),
        .addr_strap_i(strap), .status_i(status_v), .type_i(type_v), .irq_set_i(irq_set),
        .mode_o(mode_o), .ctrl_o(ctrl_o), .mask_o(mask_o), .irq_flags_o(irq_flags),
        .man_cmd_o(man_cmd), .soft_rst_o(soft_rst)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison and pulse monitors
    logic sda_oe_p = 1'b0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if ((man_cmd & 4'b1101) != 0) begin
                seen_pulse = seen_pulse | (man_cmd & 4'b1101);
                pulse_n++;
            end
            if (soft_rst) srst_n++;
            if (sda_oe !== sda_oe_p) check(scl_m == 1'b0, "R12 sda change while SCL high", scl_m, 0);
            sda_oe_p = sda_oe;
            if (cmp_en) begin
                check({mode_o, ctrl_o, mask_o} == {e_mode, e_ctrl, e_mask}, "R3 register outputs",
                      {8'h0, mode_o, ctrl_o, mask_o}, {8'h0, e_mode, e_ctrl, e_mask});
                check(irq_flags == e_flags, "R8 irq_flags_o", irq_flags, e_flags);
                check(man_cmd[1] == e_dis, "R9 held disable", man_cmd[1], e_dis);
            end
        end
    end

    initial begin
        wait (cycles >= 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic m_start();
        sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0;
    endtask

    task automatic m_stop();
        hold(Q); sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(2 * Q);
    endtask

    // gl: 1 = 6-cycle SCL spike in the low phase, 2 = 6-cycle SDA dip in the high phase
    task automatic send_bit(input logic b, input int gl);
        hold(Q); sda_m = b;
        if (gl == 1) begin hold(4); gl_scl = 1; hold(6); gl_scl = 0; hold(Q - 10); end
        else hold(Q);
        scl_m = 1;
        if (gl == 2) begin hold(Q / 2); gl_sda = 1; hold(6); gl_sda = 0; hold(2 * Q - Q / 2 - 6); end
        else hold(2 * Q);
        scl_m = 0;
    endtask

    task automatic recv_bit(output logic b);
        hold(Q); sda_m = 1; hold(Q); scl_m = 1; hold(Q); b = sda_line; hold(Q); scl_m = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, input int gl, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i], (i == 4) ? gl : 0);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(nack, 0);
    endtask

    function automatic logic [7:0] dev(input logic s, input logic rd);
        return {4'b0100, s, 2'b01, rd};
    endfunction

    task automatic model_reset();
        e_mode = 8'h04; e_ctrl = 8'h03; e_mask = 8'h00; e_flags = 4'h0; e_dis = 1'b0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        logic [3:0] p;
        case (a)
            8'h02: e_mode = d & 8'h3F;
            8'h03: e_ctrl = d & 8'h37;
            8'h10: e_mask = d & 8'h0F;
            8'h04: begin
                p = 4'h0;
                if (d[1]) e_dis = 1'b1;
                else begin
                    e_dis = 1'b0;
                    if (d[0]) p = 4'h1; else if (d[2]) p = 4'h4; else if (d[3]) p = 4'h8;
                end
                if (p != 0) begin e_pulse = e_pulse | p; e_pulse_n++; end
            end
            8'h05: if (d[0]) begin model_reset(); e_srst_n++; end
            default: ;
        endcase
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] v;
        case (a)
            8'h01: v = 8'h12;
            8'h02: v = e_mode;
            8'h03: v = e_ctrl;
            8'h04: v = {6'h0, e_dis, 1'b0};
            8'h10: v = e_mask;
            8'h11: v = status_v & 8'h3F;
            8'h12: v = type_v & 8'h1B;
            8'h13: begin v = {4'h0, e_flags}; e_flags = 4'h0; end
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // write wq[] starting at ptr; s is the strap value assumed in the address
    task automatic do_write(input logic s, input logic [7:0] ptr, input int gl, input bit exp_ack);
        bit ack;
        cmp_en = 0; e_pulse = 0; seen_pulse = 0; e_pulse_n = 0; pulse_n = 0;
        m_start();
        send_byte(dev(s, 1'b0), 0, ack);
        check(ack == exp_ack, "R1 address acknowledge", ack, exp_ack);
        if (ack) begin
            send_byte(ptr, 0, ack);
            check(ack, "R3 pointer byte ack", ack, 1);
            e_ptr = ptr;
            foreach (wq[i]) begin
                send_byte(wq[i], gl, ack);
                check(ack, "R3 data byte ack", ack, 1);
                model_write(e_ptr, wq[i]);
                e_ptr = e_ptr + 8'd1;
            end
        end
        m_stop();
        wq.delete();
        check(seen_pulse == e_pulse && pulse_n == e_pulse_n, "R9 command pulses",
              {seen_pulse, 8'(pulse_n)}, {e_pulse, 8'(e_pulse_n)});
        cmp_en = 1;
    endtask

    task automatic do_read(input bit setp, input logic [7:0] ptr, input int n, input string req);
        bit ack;
        logic [7:0] d, e;
        cmp_en = 0;
        m_start();
        if (setp) begin
            send_byte(dev(strap, 1'b0), 0, ack);
            send_byte(ptr, 0, ack);
            e_ptr = ptr;
            m_start();
        end
        send_byte(dev(strap, 1'b1), 0, ack);
        check(ack, "R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, (i == n - 1));
            e = model_read(e_ptr);
            e_ptr = e_ptr + 8'd1;
            check(d == e, req, d, e);
        end
        m_stop();
        cmp_en = 1;
    endtask

    task automatic pulse_irq(input logic [3:0] v);
        @(posedge clk); #1 irq_set = v;
        @(posedge clk); #1 irq_set = 4'h0;
        e_flags = e_flags | v;
    endtask

    initial begin
        hold(5); rst_n = 1; hold(2);
        // R2 reset state at the ports
        check(mode_o == 8'h04 && ctrl_o == 8'h03 && mask_o == 8'h00 && irq_flags == 0 && !sda_oe,
              "R2 reset outputs", {mode_o, ctrl_o, mask_o}, 24'h040300);
        cmp_en = 1;
        do_read(1, 8'h01, 3, "R2 reset readback of 0x01..0x03");
        // R3 burst write, R5 reserved bits dropped
        wq = '{8'hE1, 8'hFF}; do_write(0, 8'h02, 0, 1);
        wq = '{8'hFA}; do_write(0, 8'h10, 0, 1);
        do_read(1, 8'h02, 2, "R5 writable bits of 0x02/0x03");
        // R4/R7 read from current pointer (0x11 after the mask write) with live inputs
        wq = '{8'hFA}; do_write(0, 8'h10, 0, 1);
        status_v = 8'hFF; type_v = 8'hFF;
        do_read(0, 8'h00, 3, "R4 R7 resume at pointer, status/type masks");
        status_v = 8'h15; type_v = 8'h08;
        do_read(1, 8'h11, 2, "R7 live status/type");
        // R8 flags set, read-clear, second read empty
        pulse_irq(4'h5);
        do_read(1, 8'h13, 1, "R8 flag read");
        do_read(1, 8'h13, 1, "R8 flags cleared by read");
        pulse_irq(4'hA);
        do_read(1, 8'h12, 3, "R8 R5 burst across 0x13 into 0x14");
        // R1 strap: wrong address ignored, right one accepted
        strap = 1;
        wq = '{8'h11}; do_write(0, 8'h02, 0, 0);
        check(mode_o == e_mode, "R1 no effect of foreign address", mode_o, e_mode);
        wq = '{8'h11}; do_write(1, 8'h02, 0, 1);
        do_read(1, 8'h02, 1, "R1 strap-high address read");
        // R5 reserved address, R6 read-only ID
        wq = '{8'hAA}; do_write(1, 8'h08, 0, 1);
        wq = '{8'hFF}; do_write(1, 8'h01, 0, 1);
        do_read(1, 8'h00, 2, "R6 R5 ID and reserved reads");
        do_read(1, 8'h08, 1, "R5 reserved write dropped");
        // R9 command register priorities and held disable
        wq = '{8'h0D}; do_write(1, 8'h04, 0, 1);
        wq = '{8'h0C}; do_write(1, 8'h04, 0, 1);
        wq = '{8'h0F}; do_write(1, 8'h04, 0, 1);
        do_read(1, 8'h04, 1, "R9 disable reads back");
        wq = '{8'h08}; do_write(1, 8'h04, 0, 1);
        do_read(1, 8'h04, 1, "R9 disable cleared");
        // R11 glitches on SCL (low phase) and SDA (high phase) rejected
        wq = '{8'h35, 8'hF7}; do_write(1, 8'h02, 1, 1);
        wq = '{8'h3B}; do_write(1, 8'h10, 2, 1);
        do_read(1, 8'h02, 2, "R11 data after SCL spike");
        do_read(1, 8'h10, 1, "R11 data after SDA dip");
        // R10 soft reset
        pulse_irq(4'h3);
        wq = '{8'h0F}; do_write(1, 8'h04, 0, 1);
        srst_n = 0;
        wq = '{8'h01}; do_write(1, 8'h05, 0, 1);
        check(srst_n == 1, "R10 soft reset pulse count", srst_n, 1);
        check(mode_o == 8'h04 && ctrl_o == 8'h03 && irq_flags == 0 && man_cmd == 0,
              "R10 registers restored", {mode_o, ctrl_o, 4'h0, irq_flags}, 24'h040300);
        do_read(1, 8'h02, 4, "R10 readback after soft reset");
        hold(10);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule